// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block produces a serial test bit stream for a transmit data path. Each cycle in which the bit-enable input is high yields one bit. The bit comes from one of two sources. The first is a pseudo-random generator: a shift register with a runtime-programmable length and a single programmable feedback tap. The second is a stored word of programmable length that is sent again and again. A load strobe commits the mode, length, tap and seed/pattern word, and it is honoured only while the block is enabled.

Deliberate bit errors can be placed on the stream in three ways. A single-shot strobe inverts the next bit. Each edge on an asynchronous error pin does the same. A decade-rate setting inverts every 10^k-th bit. An inversion changes only the bit on the output. The generator's internal sequence continues untouched, so a downstream checker sees isolated single-bit errors.

Top module: `tpg_top`

## Requirements
- R1: In pseudo-random mode with length n and tap y, the output bit is state bit n-1 and the state shifts left by one within n bits. The new bit 0 is state[n-1] XOR state[y-1], which realises x^n + x^y + 1. A tap outside 1..n-1 adds no term, and the state then simply rotates.
- R2: A load while enable is high latches the mode (mode_sel 0 = pseudo-random, 1 = repeating word), the length, the tap and the low n bits of cfg_seed. A length of 0 is taken as 1, and a length above 32 is taken as 32. A load has priority over bit production in the same cycle and produces no bit.
- R3: A pseudo-random load whose masked seed is zero sets the low n state bits to all ones, so the first n bits out are ones.
- R4: In repeating-word mode the low n bits of the loaded word are sent from bit n-1 down to bit 0, then repeated without a gap.
- R5: A bit appears on tx_bit with tx_vld high in the cycle after the clock edge at which enable and bit_en were both high and load was low. tx_bit is 0 whenever tx_vld is low. After reset both outputs are 0.
- R6: While enable is low, load, bit production and single-shot and pin error requests have no effect.
- R7: Cycles with bit_en low hold the generator state, so the sequence resumes exactly where it stopped.
- R8: A single-shot strobe inverts exactly the next produced bit, or the bit produced in the same cycle. Several strobes before one produced bit invert only that one bit.
- R9: Every rising and every falling edge on err_pin, after two synchroniser flops, requests one inversion in the same way as R8.
- R10: With err_rate = k in 1..7, every 10^k-th bit produced since the last load or the last rate-inserted error is inverted.
- R11: err_rate = 0 disables rate insertion.
- R12: An inserted error never changes the generator state: the bits that follow continue the undisturbed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable |
| mode_sel | input | 1 | 0 pseudo-random, 1 repeating word |
| cfg_len | input | 6 | Register/word length n |
| cfg_tap | input | 6 | Feedback tap y |
| cfg_seed | input | 32 | Seed or repeating word |
| load | input | 1 | Commit configuration strobe |
| bit_en | input | 1 | Produce one bit this cycle |
| err_single | input | 1 | Single-shot error request |
| err_pin | input | 1 | Asynchronous error pin, both edges count |
| err_rate | input | 3 | Decade rate exponent k, 0 = off |
| tx_bit | output | 1 | Serial test bit |
| tx_vld | output | 1 | tx_bit carries a produced bit |

## Verification
The hardest case to reach is the error pin: an edge has to cross two synchroniser flops and an edge detector, and only then does it land on a produced bit. The stimulus toggles the pin while bit_en is held low and waits several idle cycles so that the request is pending. It then produces a bit and expects exactly that bit to be inverted, once for a rising edge and once for a falling edge. Decade-rate insertion is made visible by loading a one-bit all-zero repeating word, so that every inverted position stands out as a one.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TPG_MAXW     = 32;
    localparam int TPG_LENW     = 6;
    localparam int TPG_RATEW    = 3;
    localparam int TPG_RATE_MAX = 7;
    localparam int TPG_CNTW     = 24;
    localparam int TPG_SYNC     = 2;

    typedef enum logic {
        PAT_PRBS = 1'b0,
        PAT_WORD = 1'b1
    } pat_mode_e;

    typedef struct packed {
        pat_mode_e             mode;
        logic [TPG_LENW-1:0]   len;
        logic [TPG_LENW-1:0]   tap;
    } pat_cfg_t;

    typedef struct packed {
        logic vld;
        logic data;
    } tx_beat_t;

    // Bring a requested length into the legal range 1..TPG_MAXW.
    function automatic logic [TPG_LENW-1:0] clamp_len(input logic [TPG_LENW-1:0] l);
        if (l == '0)
            return TPG_LENW'(1);
        else if (int'(l) > TPG_MAXW)
            return TPG_LENW'(TPG_MAXW);
        else
            return l;
    endfunction

    // Is the rate exponent a legal decade setting?
    function automatic logic rate_on(input logic [TPG_RATEW-1:0] k);
        return (int'(k) >= 1) && (int'(k) <= TPG_RATE_MAX);
    endfunction

    // 10^k as a terminal count for the rate counter.
    function automatic logic [TPG_CNTW-1:0] decade_limit(input logic [TPG_RATEW-1:0] k);
        logic [TPG_CNTW-1:0] v;
        v = TPG_CNTW'(1);
        for (int i = 1; i <= TPG_RATE_MAX; i++) begin
            if (i <= int'(k))
                v = v * TPG_CNTW'(10);
        end
        return v;
    endfunction

endpackage

// File: rtl/tpg_shift_gen.sv
module tpg_shift_gen
    import tpg_pkg::*;
#(
    parameter int W = TPG_MAXW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic           adv,
    input  pat_cfg_t       cfg_in,
    input  logic [W-1:0]   seed,
    output logic           cur_bit
);

    localparam int IW = $clog2(W);

    pat_cfg_t              cfg_q;
    logic [W-1:0]          st_q;
    logic [W-1:0]          st_nxt;
    logic [W-1:0]          cur_mask;
    logic [W-1:0]          ld_mask;
    logic [W-1:0]          ld_val;
    logic [TPG_LENW-1:0]   ld_len;
    logic [IW-1:0]         hi_idx;
    logic [IW-1:0]         tap_idx;
    logic                  tap_ok;
    logic                  hi_bit;
    logic                  fb;

    // Ones in the low l positions.
    function automatic logic [W-1:0] mask_of(input logic [TPG_LENW-1:0] l);
        logic [W-1:0] m;
        m = '0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(l))
                m[i] = 1'b1;
        end
        return m;
    endfunction

    // Load path: clamp length, mask the seed, avoid the all-zero lock-up.
    always_comb begin
        ld_len  = clamp_len(cfg_in.len);
        ld_mask = mask_of(ld_len);
        ld_val  = seed & ld_mask;
        if (cfg_in.mode == PAT_PRBS && ld_val == '0)
            ld_val = ld_mask;
    end

    // Step path: shared by both modes; the word mode has no tap term.
    always_comb begin
        cur_mask = mask_of(cfg_q.len);
        hi_idx   = IW'(cfg_q.len - TPG_LENW'(1));
        tap_idx  = IW'(cfg_q.tap - TPG_LENW'(1));
        tap_ok   = (cfg_q.mode == PAT_PRBS) && (cfg_q.tap != '0) && (cfg_q.tap < cfg_q.len);
        hi_bit   = st_q[hi_idx];
        fb       = hi_bit ^ (tap_ok & st_q[tap_idx]);
        st_nxt   = {st_q[W-2:0], fb} & cur_mask;
        cur_bit  = hi_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: PAT_PRBS, len: TPG_LENW'(1), tap: '0};
            st_q  <= '0;
        end else if (ld) begin
            cfg_q <= '{mode: cfg_in.mode, len: ld_len, tap: cfg_in.tap};
            st_q  <= ld_val;
        end else if (adv) begin
            st_q  <= st_nxt;
        end
    end

    AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (ld && cfg_in.mode == PAT_PRBS) |=> (st_q != '0));  // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv) |=> $stable(st_q));  // R7

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ld |=> (cfg_q.len != '0 && int'(cfg_q.len) <= W));  // R2

endmodule

// File: rtl/tpg_err_sync.sv
module tpg_err_sync
    import tpg_pkg::*;
#(
    parameter int STAGES = TPG_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic edge_pulse
);

    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sr_q[STAGES-1];
    end

    assign edge_pulse = sr_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/tpg_rate_ins.sv
module tpg_rate_ins
    import tpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  adv,
    input  logic [TPG_RATEW-1:0]  rate,
    output logic                  hit
);

    logic [TPG_CNTW-1:0] cnt_q;
    logic [TPG_CNTW-1:0] lim_m1;
    logic                on;

    always_comb begin
        on     = rate_on(rate);
        lim_m1 = decade_limit(rate) - TPG_CNTW'(1);
        hit    = on && adv && (cnt_q == lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !on)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= hit ? '0 : cnt_q + TPG_CNTW'(1);
    end

    AST_RATE_RESTART: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt_q == '0));  // R10

    AST_RATE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |=> (cnt_q == '0));  // R11

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  mode_sel,
    input  logic [TPG_LENW-1:0]   cfg_len,
    input  logic [TPG_LENW-1:0]   cfg_tap,
    input  logic [TPG_MAXW-1:0]   cfg_seed,
    input  logic                  load,
    input  logic                  bit_en,
    input  logic                  err_single,
    input  logic                  err_pin,
    input  logic [TPG_RATEW-1:0]  err_rate,
    output logic                  tx_bit,
    output logic                  tx_vld
);

    pat_cfg_t  cfg_in;
    tx_beat_t  beat_q;
    logic      ld;
    logic      adv;
    logic      gen_bit;
    logic      pin_pulse;
    logic      rate_hit;
    logic      req;
    logic      pend_q;
    logic      flip;

    always_comb begin
        cfg_in = '{mode: pat_mode_e'(mode_sel), len: cfg_len, tap: cfg_tap};
        ld     = load && enable;
        adv    = enable && bit_en && !load;
        req    = enable && (err_single || pin_pulse);
        flip   = adv && (pend_q || req || rate_hit);
    end

    tpg_shift_gen #(.W(TPG_MAXW)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld),
        .adv     (adv),
        .cfg_in  (cfg_in),
        .seed    (cfg_seed),
        .cur_bit (gen_bit)
    );

    tpg_err_sync #(.STAGES(TPG_SYNC)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin        (err_pin),
        .edge_pulse (pin_pulse)
    );

    tpg_rate_ins u_rate (
        .clk  (clk),
        .rst  (rst),
        .clr  (ld),
        .adv  (adv),
        .rate (err_rate),
        .hit  (rate_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (adv)
            pend_q <= 1'b0;
        else if (req)
            pend_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '{vld: 1'b0, data: 1'b0};
        else if (adv)
            beat_q <= '{vld: 1'b1, data: gen_bit ^ flip};
        else
            beat_q <= '{vld: 1'b0, data: 1'b0};
    end

    assign tx_bit = beat_q.data;
    assign tx_vld = beat_q.vld;

    AST_VLD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        tx_vld |-> $past(enable && bit_en && !load));  // R5

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !tx_vld);  // R6

    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
        adv |=> !pend_q);  // R8

endmodule

// File: tb/tb_tpg_top.sv
`timescale 1ns/1ps
module tb_tpg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        mode_sel = 1'b0;
    logic [5:0]  cfg_len = '0;
    logic [5:0]  cfg_tap = '0;
    logic [31:0] cfg_seed = '0;
    logic        load = 1'b0;
    logic        bit_en = 1'b0;
    logic        err_single = 1'b0;
    logic        err_pin = 1'b0;
    logic [2:0]  err_rate = '0;
    logic        tx_bit;
    logic        tx_vld;

    int   vec = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic got_bit, got_vld;

    // Reference model state
    logic [31:0] m_s;
    int          m_len, m_tap;
    bit          m_mode;
    int          rate_pos;

    always #2.5 clk = ~clk;

    tpg_top dut (
        .clk(clk), .rst(rst), .enable(enable), .mode_sel(mode_sel),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_seed(cfg_seed),
        .load(load), .bit_en(bit_en), .err_single(err_single),
        .err_pin(err_pin), .err_rate(err_rate),
        .tx_bit(tx_bit), .tx_vld(tx_vld)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_n(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic cyc(input bit b, input bit ld, input bit se);
        @(negedge clk);
        bit_en = b; load = ld; err_single = se;
        @(posedge clk);
        #1;
        got_bit = tx_bit;
        got_vld = tx_vld;
    endtask

    task automatic m_adv(output bit b);
        bit fb;
        b  = m_s[m_len-1];
        fb = b;
        if (!m_mode && m_tap >= 1 && m_tap < m_len) fb = fb ^ m_s[m_tap-1];
        m_s = ((m_s << 1) | {31'd0, fb}) & mask_n(m_len);
    endtask

    task automatic load_pat(input bit md, input int len, input int tap, input logic [31:0] seed);
        mode_sel = md; cfg_len = 6'(len); cfg_tap = 6'(tap); cfg_seed = seed;
        cyc(1'b1, 1'b1, 1'b0);
        m_mode = md;
        m_len  = (len == 0) ? 1 : ((len > 32) ? 32 : len);
        m_tap  = tap;
        m_s    = seed & mask_n(m_len);
        if (!md && m_s == 0) m_s = mask_n(m_len);
        rate_pos = 0;
        chk(!got_vld, "R2", {31'd0, got_vld}, 0);
    endtask

    task automatic one_bit(input bit se, input bit flip, input string req);
        bit e;
        cyc(1'b1, 1'b0, se);
        m_adv(e);
        e ^= flip;
        chk(got_vld && got_bit == e, req, {30'd0, got_vld, got_bit}, {30'd0, 1'b1, e});
    endtask

    task automatic run_bits(input int n, input int period, input string req);
        bit e;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            m_adv(e);
            if (period != 0) begin
                rate_pos++;
                if (rate_pos == period) begin e ^= 1'b1; rate_pos = 0; end
            end
            chk(got_vld && got_bit == e, req, {30'd0, got_vld, got_bit}, {30'd0, 1'b1, e});
        end
    endtask

    task automatic t_reset;
        chk(tx_vld == 1'b0 && tx_bit == 1'b0, "R5", {30'd0, tx_vld, tx_bit}, 0);
    endtask

    task automatic t_prbs;
        enable = 1'b1;
        load_pat(1'b0, 7, 6, 32'h55);
        run_bits(140, 0, "R1");
        load_pat(1'b0, 32, 22, 32'hDEADBEEF);
        run_bits(80, 0, "R1");
        load_pat(1'b0, 4, 0, 32'h9);       // tap out of range: rotation
        run_bits(12, 0, "R1");
    endtask

    task automatic t_zero_seed;
        load_pat(1'b0, 5, 3, 32'hFFFF_FFE0); // low 5 bits zero
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            chk(got_bit == 1'b1, "R3", {31'd0, got_bit}, 1);
            begin bit d; m_adv(d); end
        end
        run_bits(40, 0, "R3");
    endtask

    task automatic t_word;
        load_pat(1'b1, 5, 0, 32'h16);       // 10110 MSB first
        run_bits(15, 0, "R4");
        load_pat(1'b1, 32, 0, 32'hF00D_1234);
        run_bits(70, 0, "R4");
        load_pat(1'b1, 0, 0, 32'h1);        // length 0 -> 1, constant ones
        run_bits(4, 0, "R2");
        load_pat(1'b1, 40, 0, 32'h8000_0001); // length >32 -> 32
        run_bits(34, 0, "R2");
    endtask

    task automatic t_gaps;
        load_pat(1'b0, 9, 5, 32'h1A5);
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b0, 1'b0);
            chk(!got_vld && !got_bit, "R5", {30'd0, got_vld, got_bit}, 0);
            cyc(1'b0, 1'b0, 1'b0);
            run_bits(3, 0, "R7");
        end
    endtask

    task automatic t_disabled;
        load_pat(1'b1, 8, 0, 32'hA5);
        run_bits(3, 0, "R6");
        enable = 1'b0;
        mode_sel = 1'b0; cfg_len = 6'd3; cfg_seed = 32'h7;
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b1);
        chk(!got_vld, "R6", {31'd0, got_vld}, 0);
        cyc(1'b0, 1'b0, 1'b1);
        enable = 1'b1;
        run_bits(16, 0, "R6");
    endtask

    task automatic t_single;
        load_pat(1'b0, 7, 6, 32'h1);
        run_bits(5, 0, "R8");
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b1);
        one_bit(1'b0, 1'b1, "R8");
        run_bits(10, 0, "R12");
        one_bit(1'b1, 1'b1, "R8");
        run_bits(10, 0, "R12");
    endtask

    task automatic t_pin;
        load_pat(1'b1, 4, 0, 32'h9);
        run_bits(3, 0, "R9");
        err_pin = 1'b1;
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0);
        one_bit(1'b0, 1'b1, "R9");
        run_bits(6, 0, "R9");
        err_pin = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0);
        one_bit(1'b0, 1'b1, "R9");
        run_bits(6, 0, "R12");
    endtask

    task automatic t_rate;
        err_rate = 3'd1;
        load_pat(1'b1, 1, 0, 32'h0);
        run_bits(30, 10, "R10");
        err_rate = 3'd2;
        load_pat(1'b1, 1, 0, 32'h0);
        run_bits(250, 100, "R10");
        err_rate = 3'd0;
        load_pat(1'b1, 1, 0, 32'h0);
        run_bits(40, 0, "R11");
    endtask

    initial begin
        #500000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0);
        t_reset();
        t_prbs();
        t_zero_seed();
        t_word();
        t_gaps();
        t_disabled();
        t_single();
        t_pin();
        t_rate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule